// File: doc/BRIEF.md
# Dual-Reference Selection Controller

This controller chooses which of two timing references, primary or secondary, a digital PLL should follow. Every clock it looks at a validity bit for each reference, a two-bit failure-detect mode and a preference bit. From these it drives three things: the index of the selected reference, a holdover level that tells the loop to run on its stored values, and a one-cycle pulse each time the selection changes. It also gives one fail flag per reference.

Autodetect mode is revertive. The controller follows the preferred reference. When the reference it is following fails, it drops into holdover for a programmable minimum time and then takes up the backup. When the preferred reference comes back, it returns to it. Software can stop that return by pointing the preference bit at the backup once the fallback has happened.

The two forced modes tie the loop to one reference. They wait in holdover through any outage of that reference and never fall back to the other one. The mode and preference inputs are registered inside the block, so each change is seen by the decision logic one cycle after it is captured.

Top module: `dual_ref_selector`

## Requirements
- R1: While reset is low, the outputs are sel_o=0 (primary), holdover_o=0, switch_o=0 and fail_o=2'b00.
- R2: The mode field encodes 2'b00 as autodetect, 2'b01 as forced primary, 2'b10 as forced secondary and 2'b11 as autodetect. Mode and preference are registered before use. The first decision after reset uses autodetect with primary preferred.
- R3: In autodetect mode with both references valid, the block selects the reference named by pref_i (0 = primary, 1 = secondary). When the current reference is still valid, this change of selection happens in one cycle with no holdover.
- R4: When the current reference becomes invalid, holdover_o goes high on the next cycle. It stays high for at least HOLD_MIN cycles. It stays high for exactly HOLD_MIN cycles if a usable target is present when that time is up.
- R5: In autodetect mode, once the preferred reference is valid again while the backup is being followed, the block switches straight back to the preferred reference.
- R6: If pref_i is changed to point at the backup after the fallback, the block stays on the backup even when the former reference recovers.
- R7: With both references invalid, holdover_o stays high until one becomes valid. The block then selects that reference.
- R8: In forced primary mode (or forced secondary mode), only that reference is ever selected and pref_i has no effect. If it fails, the block holds in holdover until it recovers, and then resumes it without a switch pulse.
- R9: fail_o[0] and fail_o[1] equal the inverse of ref_valid_i[0] and ref_valid_i[1] as sampled on the previous edge, whatever the mode or preference.
- R10: switch_o is high for exactly the cycles in which sel_o differs from its value one cycle earlier.
- R11: sel_o does not change while holdover_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid_i | input | 2 | Validity per reference, bit 0 primary, bit 1 secondary |
| mode_i | input | 2 | Failure-detect mode |
| pref_i | input | 1 | Preferred reference, 0 primary, 1 secondary |
| sel_o | output | 1 | Selected reference index |
| holdover_o | output | 1 | Holdover level |
| switch_o | output | 1 | One-cycle pulse on change of selection |
| fail_o | output | 2 | Fail flag per reference |

## Verification
The bench builds the controller with HOLD_MIN set to 4. At that value a complete holdover window, its exact exit cycle and a saturated wait during a double outage all fit in a few dozen cycles. The short window also makes the case of a forced reference that recovers before the minimum time has passed easy to reach. The counter variant of the hold timer is the one exercised. The single-cycle variant is selected only when HOLD_MIN is 1.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

   localparam int unsigned NREF = 2;

   typedef enum logic [1:0] {
      MODE_AUTO      = 2'b00,
      MODE_FORCE_PRI = 2'b01,
      MODE_FORCE_SEC = 2'b10,
      MODE_AUTO_ALT  = 2'b11
   } mode_t;

   typedef enum logic {
      ST_TRACK = 1'b0,
      ST_HOLD  = 1'b1
   } sel_state_t;

   typedef struct packed {
      logic ok;
      logic idx;
   } pick_t;

endpackage

// File: rtl/ref_pick.sv
module ref_pick
   import ref_sel_pkg::*;
(
   input  mode_t            mode,
   input  logic             pref,
   input  logic [NREF-1:0]  valid,
   output pick_t            want
);

   logic other;
   assign other = ~pref;

   always_comb begin
      want = '0;
      case (mode)
         MODE_FORCE_PRI: begin
            want.ok  = valid[0];
            want.idx = 1'b0;
         end
         MODE_FORCE_SEC: begin
            want.ok  = valid[1];
            want.idx = 1'b1;
         end
         default: begin
            if (valid[pref]) begin
               want.ok  = 1'b1;
               want.idx = pref;
            end else if (valid[other]) begin
               want.ok  = 1'b1;
               want.idx = other;
            end
         end
      endcase
   end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int unsigned HOLD_MIN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_hold,
   output logic done
);

   localparam int unsigned CNT_W = (HOLD_MIN > 2) ? $clog2(HOLD_MIN) : 1;
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_MIN - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!in_hold) begin
         cnt <= '0;
      end else if (cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == LIMIT);

endmodule

// File: rtl/fail_flags.sv
module fail_flags
   import ref_sel_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREF-1:0] valid,
   output logic [NREF-1:0] fail
);

   for (genvar i = 0; i < NREF; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fail[i] <= 1'b0;
         else        fail[i] <= ~valid[i];
      end
   end

endmodule

// File: rtl/dual_ref_selector.sv
module dual_ref_selector
   import ref_sel_pkg::*;
#(
   parameter int unsigned HOLD_MIN = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ref_valid_i,
   input  logic [1:0] mode_i,
   input  logic       pref_i,
   output logic       sel_o,
   output logic       holdover_o,
   output logic       switch_o,
   output logic [1:0] fail_o
);

   initial begin : p_param_chk
      assert (HOLD_MIN >= 1) else $error("HOLD_MIN must be at least 1");
   end

   // registered configuration, reset to autodetect / primary preferred
   mode_t      mode_q;
   logic       pref_q;
   sel_state_t state_q, state_d;
   logic       sel_q, sel_d;
   logic       sw_q;
   logic       tmr_done;
   pick_t      want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_AUTO;
         pref_q <= 1'b0;
      end else begin
         mode_q <= mode_t'(mode_i);
         pref_q <= pref_i;
      end
   end

   ref_pick u_pick (
      .mode  (mode_q),
      .pref  (pref_q),
      .valid (ref_valid_i),
      .want  (want)
   );

   if (HOLD_MIN > 1) begin : g_timer
      hold_timer #(.HOLD_MIN(HOLD_MIN)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_hold (state_q == ST_HOLD),
         .done    (tmr_done)
      );
   end else begin : g_no_timer
      assign tmr_done = 1'b1;
   end

   always_comb begin
      state_d = state_q;
      sel_d   = sel_q;
      case (state_q)
         ST_TRACK: begin
            if (!want.ok || !ref_valid_i[sel_q]) state_d = ST_HOLD;
            else                                 sel_d   = want.idx;
         end
         default: begin
            if (want.ok && tmr_done) begin
               state_d = ST_TRACK;
               sel_d   = want.idx;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_TRACK;
         sel_q   <= 1'b0;
         sw_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         sel_q   <= sel_d;
         sw_q    <= (sel_d != sel_q);
      end
   end

   fail_flags u_fail (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (ref_valid_i),
      .fail  (fail_o)
   );

   assign sel_o      = sel_q;
   assign holdover_o = (state_q == ST_HOLD);
   assign switch_o   = sw_q;

endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk
   import ref_sel_pkg::*;
#(
   parameter int unsigned HOLD_MIN = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] ref_valid_i,
   input logic       sel_o,
   input logic       holdover_o,
   input logic       switch_o,
   input logic [1:0] fail_o,
   input mode_t      mode_q
);

   localparam int unsigned RUN_W = $clog2(HOLD_MIN + 1) + 1;

   logic             seen;
   logic [RUN_W-1:0] hold_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         hold_run <= '0;
      end else begin
         seen <= 1'b1;
         if (!holdover_o)                    hold_run <= '0;
         else if (hold_run < RUN_W'(HOLD_MIN)) hold_run <= hold_run + 1'b1;
      end
   end

   // R10
   switch_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o == (sel_o != $past(sel_o)));

   // R11
   hold_freezes_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      holdover_o |-> $stable(sel_o));

   // R4
   hold_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(holdover_o) |-> (hold_run >= RUN_W'(HOLD_MIN)));

   // R9
   fail_tracks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (fail_o == ~$past(ref_valid_i)));

   // R8
   forced_pri_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_o && $past(mode_q) == MODE_FORCE_PRI) |-> (sel_o == 1'b0));

   // R8
   forced_sec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_o && $past(mode_q) == MODE_FORCE_SEC) |-> (sel_o == 1'b1));

   // R10
   no_switch_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o |-> !holdover_o);

endmodule

bind dual_ref_selector ref_sel_chk #(.HOLD_MIN(HOLD_MIN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ref_valid_i (ref_valid_i),
   .sel_o       (sel_o),
   .holdover_o  (holdover_o),
   .switch_o    (switch_o),
   .fail_o      (fail_o),
   .mode_q      (mode_q)
);

// File: tb/sim_dual_ref_selector.sv
module sim_dual_ref_selector;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD_MIN   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_valid_i = 2'b11;
   logic [1:0] mode_i = 2'b10;
   logic       pref_i = 1'b0;
   logic       sel_o, holdover_o, switch_o;
   logic [1:0] fail_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [4:0] val;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_ref_selector #(.HOLD_MIN(HOLD_MIN)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_valid_i (ref_valid_i),
      .mode_i      (mode_i),
      .pref_i      (pref_i),
      .sel_o       (sel_o),
      .holdover_o  (holdover_o),
      .switch_o    (switch_o),
      .fail_o      (fail_o)
   );

   // expected: {sel, hold, switch, fail[1:0]} after the next rising edge
   task automatic step(input logic [1:0] v, input logic [1:0] m, input logic p,
                       input logic es, input logic eh, input logic esw,
                       input logic [1:0] ef, input string tag);
      exp_t e;
      @(negedge clk);
      rst_n       = 1'b1;
      ref_valid_i = v;
      mode_i      = m;
      pref_i      = p;
      e.val = {es, eh, esw, ef};
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() != 0) begin
            exp_t e;
            logic [4:0] act;
            e = q.pop_front();
            act = {sel_o, holdover_o, switch_o, fail_o};
            checks++;
            if (act !== e.val) begin
               errors++;
               $display("FAIL %s: got sel/hold/sw/fail=%b expected %b", e.tag, act, e.val);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   // driver
   initial begin
      repeat (3) @(posedge clk);
      #2;
      checks++;
      if ({sel_o, holdover_o, switch_o, fail_o} !== 5'b00000) begin
         errors++;
         $display("FAIL R1 reset: got %b expected 00000", {sel_o, holdover_o, switch_o, fail_o});
      end
      // R2: first decision after reset uses autodetect, primary preferred
      step(2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, "R2 first cycle auto");
      step(2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, "R8 forced secondary taken");
      step(2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, "R2 config latency");
      step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, "R3 direct switch to preferred");
      // R4: primary fails, holdover for HOLD_MIN cycles then backup
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R4 holdover entry");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R4 holdover 2");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R4 holdover 3");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R4 holdover 4");
      step(2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, "R4 backup taken");
      step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, "R5 revert to preferred");
      // fall back again, then re-point preference to hold the backup
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R4 second holdover");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R11 sel frozen");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R11 sel frozen");
      step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R11 sel frozen");
      step(2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, "R4 backup again");
      step(2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, "R6 preference moved");
      step(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R6 stays on backup");
      step(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R6 stays on backup");
      // R7: both invalid
      step(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, "R7 both lost");
      for (int i = 0; i < 5; i++)
         step(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, "R7 holdover persists");
      step(2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, "R7 takes recovered primary");
      // R8: forced primary, preference ignored
      step(2'b11, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, "R3 auto to secondary");
      step(2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, "R8 forced primary ignores pref");
      step(2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, "R8 forced primary lost");
      for (int i = 0; i < 5; i++)
         step(2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, "R8 no fallback");
      step(2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, "R8 resume without pulse");
      // R2: encoding 11 acts as autodetect
      step(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, "R2 mode latency");
      step(2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, "R2 mode 11 autodetect");
      // R4: minimum holdover even when the reference returns early
      step(2'b01, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, "R4 secondary lost");
      step(2'b11, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R4 min hold 2");
      step(2'b11, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R4 min hold 3");
      step(2'b11, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R4 min hold 4");
      step(2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R8 forced secondary resumes");
      wait (q.size() == 0);
      @(posedge clk);
      #3;
      finish_run();
   end

endmodule